// File: doc/BRIEF.md
# Touch Key Group Arbiter

This block decides, once per measurement sample, which of seven touch keys are allowed to hold a detect state. Each key's integrator reports whether the key is ready to enter detect, whether it is still filtering in, whether an already detected key is still touched, and how large its signal change is. The arbiter resolves competition inside up to three suppression groups and lets one optional guard key take priority over every other key.

Inside a group, only one key can be in detect at a time. When several members are ready together, the one with the largest signal change wins. A key that already holds detect locks its group until it releases. Keys outside any group pass straight through. When the guard key starts filtering in, the arbiter asks the integrators of the other competing keys to restart. While the guard key is in detect, every other key is reported as untouched.

All outputs are registered on the sample strobe. The group fields are meant to be reconfigured only while no key holds detect.

Top module: `keyarb_top`

## Requirements
- R1: Key k takes its 2-bit group number from bits [2k+1:2k] of `group_i`. Value 0 means the key is in no group, and values 1 to 3 name a suppression group.
- R2: At most one key per group 1–3 holds detect. While a member of a group holds detect and its `keep_i` bit is high, no other member of that group enters.
- R3: Among the ready, not-yet-held members of an unlocked group, only the one with the strictly largest 16-bit change enters. On equal change, the lowest key number wins.
- R4: A group-0 key that is ready and not held enters detect, whatever the other keys are doing.
- R5: A held key stays held on each strobe where its `keep_i` is 1, and it releases on the strobe where `keep_i` is 0. `grant_o` bit k shows the held state of key k.
- R6: `guard_sel_i` values 0 to 6 select that key as guard. Values 7 to 15 disable the guard function, and no integrator-reset request is then raised.
- R7: When the guard key is not held and has `filt_i` or `want_i` high, every other key that is not held and has `filt_i` or `want_i` high gets its `irst_o` bit set for that sample period. Such a key does not enter detect on that strobe.
- R8: While the selected guard key holds detect, `status_o` shows only the guard key's bit.
- R9: `status_o` bit 7 is always 0 and bits 0–6 are the reported keys 0–6. `touch_o` is the OR of the reported keys.
- R10: Outputs change only at a clock edge where `sample_i` was high. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Measurement strobe; arbitration registers on it |
| want_i | input | 7 | Per key: integrator reached its count, ready to enter detect |
| filt_i | input | 7 | Per key: touch present, integrator still counting |
| keep_i | input | 7 | Per key: a held key is still touched |
| delta_i | input | 112 | Per key 16-bit signal change, key k at [16k+15:16k] |
| group_i | input | 14 | Per key 2-bit group number |
| guard_sel_i | input | 4 | Guard key index; 7 and above disable the guard |
| grant_o | output | 7 | Held detect state per key |
| irst_o | output | 7 | Integrator-reset request per key |
| status_o | output | 8 | Reported key status byte |
| touch_o | output | 1 | Any reported key in detect |

## Verification
A corrupted held vector surfaces on the strobe after the fault. It appears as a second grant in one group, a key that drops out while still touched, or a status byte that disagrees with the grants under guard masking. A wrong winner choice shows up in the very sample where two members of a group compete, so near-ties in the change values are driven deliberately. Every port is compared one cycle after each strobe against an arithmetic model, so a divergence is reported no later than the sample that produced it.

// File: rtl/keyarb_pkg.sv
package keyarb_pkg;
    localparam int GRP_W    = 2;
    localparam int GRP_CNT  = 1 << GRP_W;
    localparam int GUARD_W  = 4;
endpackage

// File: rtl/keyarb_group_pick.sv
module keyarb_group_pick #(
    parameter int N  = 7,
    parameter int DW = 16
) (
    input  logic [N-1:0]    req,
    input  logic [N*DW-1:0] delta,
    output logic [N-1:0]    win
);
    logic          found;
    logic [DW-1:0] best;
    int unsigned   idx;

    always_comb begin
        win   = '0;
        found = 1'b0;
        best  = '0;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && (!found || delta[k*DW +: DW] > best)) begin
                found = 1'b1;
                best  = delta[k*DW +: DW];
                idx   = k;
            end
        end
        if (found) win[idx] = 1'b1;
    end
endmodule

// File: rtl/keyarb_guard.sv
module keyarb_guard #(
    parameter int N = 7
) (
    input  logic [keyarb_pkg::GUARD_W-1:0] sel,
    input  logic [N-1:0]                   want,
    input  logic [N-1:0]                   filt,
    input  logic [N-1:0]                   held,
    output logic                           en,
    output logic [N-1:0]                   onehot,
    output logic [N-1:0]                   block
);
    logic pre;

    always_comb begin
        en     = (32'(sel) < N);
        onehot = '0;
        for (int k = 0; k < N; k++)
            if (en && 32'(sel) == k) onehot[k] = 1'b1;
        pre   = |(onehot & (want | filt) & ~held);
        block = pre ? ~onehot : '0;
    end
endmodule

// File: rtl/keyarb_top.sv
module keyarb_top #(
    parameter int N  = 7,
    parameter int DW = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sample_i,
    input  logic [N-1:0]                      want_i,
    input  logic [N-1:0]                      filt_i,
    input  logic [N-1:0]                      keep_i,
    input  logic [N*DW-1:0]                   delta_i,
    input  logic [N*keyarb_pkg::GRP_W-1:0]    group_i,
    input  logic [keyarb_pkg::GUARD_W-1:0]    guard_sel_i,
    output logic [N-1:0]                      grant_o,
    output logic [N-1:0]                      irst_o,
    output logic [N:0]                        status_o,
    output logic                              touch_o
);
    import keyarb_pkg::*;

    typedef struct packed {
        logic [N-1:0] held;
        logic [N-1:0] irst;
        logic [N-1:0] rep;
        logic         touch;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N-1:0] member [GRP_CNT];
    logic [N-1:0] win    [GRP_CNT];
    logic [N-1:0] req    [GRP_CNT];
    logic [N-1:0] lock;
    logic [N-1:0] held_keep;
    logic [N-1:0] g_block, g_onehot;
    logic         g_en;

    assign held_keep = st_q.held & keep_i;

    keyarb_guard #(.N(N)) u_guard (
        .sel    (guard_sel_i),
        .want   (want_i),
        .filt   (filt_i),
        .held   (st_q.held),
        .en     (g_en),
        .onehot (g_onehot),
        .block  (g_block)
    );

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        for (genvar k = 0; k < N; k++) begin : g_mem
            assign member[g][k] = (group_i[k*GRP_W +: GRP_W] == GRP_W'(g));
        end
        assign lock[g] = (g != 0) && |(held_keep & member[g]);
        assign req[g]  = want_i & ~st_q.held & ~g_block & member[g]
                         & {N{~lock[g]}};
        if (g == 0) begin : g_free
            assign win[g] = req[g];
        end else begin : g_pick
            keyarb_group_pick #(.N(N), .DW(DW)) u_pick (
                .req   (req[g]),
                .delta (delta_i),
                .win   (win[g])
            );
        end
    end
    for (genvar g = GRP_CNT; g < N; g++) begin : g_lock_pad
        assign lock[g] = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        if (sample_i) begin
            st_d.held = held_keep;
            for (int g = 0; g < GRP_CNT; g++)
                st_d.held = st_d.held | win[g];
            st_d.irst = g_block & (filt_i | want_i) & ~st_q.held;
            if (g_en && |(st_d.held & g_onehot))
                st_d.rep = st_d.held & g_onehot;
            else
                st_d.rep = st_d.held;
            st_d.touch = |st_d.rep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o  = st_q.held;
    assign irst_o   = st_q.irst;
    assign status_o = {1'b0, st_q.rep};
    assign touch_o  = st_q.touch;
endmodule

// File: rtl/keyarb_chk.sv
module keyarb_chk #(
    parameter int N  = 7,
    parameter int DW = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sample_i,
    input logic [N-1:0]                   keep_i,
    input logic [N*keyarb_pkg::GRP_W-1:0] group_i,
    input logic [keyarb_pkg::GUARD_W-1:0] guard_sel_i,
    input logic [N-1:0]                   grant_o,
    input logic [N-1:0]                   irst_o,
    input logic [N:0]                     status_o,
    input logic                           touch_o
);
    logic [N-1:0] in_g1, in_g2, in_g3;
    always_comb begin
        for (int k = 0; k < N; k++) begin
            in_g1[k] = grant_o[k] && group_i[2*k +: 2] == 2'd1;
            in_g2[k] = grant_o[k] && group_i[2*k +: 2] == 2'd2;
            in_g3[k] = grant_o[k] && group_i[2*k +: 2] == 2'd3;
        end
    end

    // R2
    one_per_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_g1) <= 1 && $countones(in_g2) <= 1 && $countones(in_g3) <= 1);

    // R5
    hold_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> ((($past(grant_o) & $past(keep_i)) & ~grant_o) == '0));

    // R9
    status_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[N] == 1'b0 && touch_o == (|status_o));

    // R9
    report_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[N-1:0] & ~grant_o) == '0);

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(grant_o) && $stable(status_o) && $stable(irst_o));

    // R8
    guard_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(guard_sel_i) < N && grant_o[guard_sel_i[2:0]] && $stable(guard_sel_i))
        |-> $onehot0(status_o));
endmodule

bind keyarb_top keyarb_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/keyarb_top_bench.sv
module keyarb_top_bench;
    localparam int N  = 7;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_i = 1'b0;
    logic [N-1:0]    want_i = '0, filt_i = '0, keep_i = '0;
    logic [N*DW-1:0] delta_i = '0;
    logic [2*N-1:0]  group_i = '0;
    logic [3:0]      guard_sel_i = 4'd15;
    logic [N-1:0]    grant_o, irst_o;
    logic [N:0]      status_o;
    logic            touch_o;

    int vecs = 0, errs = 0;
    logic [N-1:0] m_held = '0, m_irst = '0, m_rep = '0;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    keyarb_top #(.N(N), .DW(DW)) u_keyarb_top (.*);

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model();
        logic [N-1:0] hk, blk, nh;
        int gk;
        bit gen, pre;
        hk  = m_held & keep_i;
        gen = guard_sel_i < N;
        gk  = gen ? int'(guard_sel_i) : 0;
        pre = gen && (filt_i[gk] || want_i[gk]) && !m_held[gk];
        blk = '0;
        for (int k = 0; k < N; k++) if (pre && k != gk) blk[k] = 1'b1;
        nh = hk;
        for (int k = 0; k < N; k++)
            if (want_i[k] && !m_held[k] && !blk[k] && group_i[2*k +: 2] == 0) nh[k] = 1'b1;
        for (int g = 1; g < 4; g++) begin
            bit locked = 0;
            int bi = -1;
            int bv = -1;
            for (int k = 0; k < N; k++)
                if (hk[k] && group_i[2*k +: 2] == g) locked = 1;
            if (!locked)
                for (int k = 0; k < N; k++)
                    if (want_i[k] && !m_held[k] && !blk[k] && group_i[2*k +: 2] == g
                        && int'(delta_i[k*DW +: DW]) > bv) begin
                        bv = int'(delta_i[k*DW +: DW]);
                        bi = k;
                    end
            if (bi >= 0) nh[bi] = 1'b1;
        end
        m_irst = blk & (filt_i | want_i) & ~m_held;
        m_held = nh;
        m_rep  = (gen && nh[gk]) ? (nh & (N'(1) << gk)) : nh;
    endtask

    task automatic step(string tag);
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        model();
        cmp({tag, " grant"},  32'(grant_o),  32'(m_held));
        cmp({tag, " irst"},   32'(irst_o),   32'(m_irst));
        cmp({tag, " status"}, 32'(status_o), {24'd0, 1'b0, m_rep});
        cmp({tag, " touch"},  32'(touch_o),  32'(|m_rep));
    endtask

    task automatic setd(int k, int v);
        delta_i[k*DW +: DW] = DW'(v);
    endtask

    task automatic setg(int k, int g);
        group_i[2*k +: 2] = 2'(g);
    endtask

    task automatic clear_all();
        want_i = '0; filt_i = '0; keep_i = '0;
        step("R5 release all");
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        #(200000 * 10);
        errs++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R10 reset grant",  32'(grant_o),  0);
        cmp("R10 reset status", 32'(status_o), 0);
        cmp("R10 reset touch",  32'(touch_o),  0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: keys 1,2 in group 2, larger change wins
        setg(1, 2); setg(2, 2); setd(1, 5); setd(2, 9);
        want_i = 7'b0000110; keep_i = '1;
        step("R3 largest");
        // R3 tie: keys 3,4 group 3 equal change
        setg(3, 3); setg(4, 3); setd(3, 7); setd(4, 7);
        want_i = 7'b0011000;
        step("R3 tie");
        // R2: key 4 still ready, key 3 holds the group
        want_i = 7'b0010000; setd(4, 100);
        step("R2 lock");
        // R4: keys 5,6 group 0 enter together
        setg(5, 0); setg(6, 0);
        want_i = 7'b1100000;
        step("R4 free");
        // R5: release key 2, key 1 of group 2 may then enter
        keep_i = 7'b1111011; want_i = 7'b0000010;
        step("R5 release");
        step("R1 reenter");
        // R10: change inputs without a strobe
        want_i = '1; keep_i = '0; guard_sel_i = 4'd0;
        @(negedge clk);
        cmp("R10 no strobe", 32'(grant_o), 32'(m_held));
        guard_sel_i = 4'd15;
        clear_all();

        // R6: disabled guard raises no reset
        setg(0, 0); setg(1, 1);
        guard_sel_i = 4'd9; filt_i = 7'b0000011; want_i = 7'b0000010; keep_i = '1;
        step("R6 disabled");
        clear_all();
        // R7: guard key 0 filtering in resets key 1
        guard_sel_i = 4'd0; filt_i = 7'b0000011; want_i = 7'b0000010; keep_i = '1;
        step("R7 preempt");
        // R8: guard enters, others masked
        want_i = 7'b0000001;
        step("R8 enter");
        want_i = 7'b0000010;
        step("R8 mask");
        clear_all();

        // sweep: segments with a fresh configuration each
        for (int seg = 0; seg < 40; seg++) begin
            lfsr = nxt(lfsr);
            group_i = lfsr[13:0];
            guard_sel_i = lfsr[17:14];
            for (int v = 0; v < 100; v++) begin
                lfsr = nxt(lfsr); want_i = lfsr[6:0];
                lfsr = nxt(lfsr); filt_i = lfsr[6:0];
                lfsr = nxt(lfsr); keep_i = lfsr[6:0] | lfsr[13:7];
                for (int k = 0; k < N; k++) begin
                    lfsr = nxt(lfsr);
                    setd(k, int'(lfsr[2:0]));
                end
                step("R2 R3 R7 R9 sweep");
            end
            clear_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule